// File: doc/BRIEF.md
# Survivor Memory and Traceback Engine

This block holds the survivor decisions of a 16-state Viterbi decoder and turns them back into decoded bits. The add-compare-select datapath delivers two decisions per beat. Eight accepted beats make one trellis stage, and that stage is stored as a 16-bit row. The stages go round-robin into three register-array banks of 28 rows each, so the memory keeps the most recent 84 stages. A one-hot write row pointer moves upward through the rows. A single one-hot read pointer moves downward, and each read cycle covers the same row in all three banks, which is three stages. In that cycle a chain of three 16-to-1 selections updates a 4-bit state: the state moves one place to the left, the old MSB is dropped, and the selected decision becomes the new LSB.

The stages are grouped in sevens of rows, which is 21 stages per group. Each time a group is complete, from the third group on, the engine starts a run. The run first performs a traceback over the newest 42 stages, starting from state 0, and throws away what it finds. It then continues with the same pointer and the same state through the 21 stages before those, pushing the recovered bits onto a stack. The stack then drains one bit per cycle, so the decoded bits come out in time order. Over time, each stage written is decoded exactly once.

Top module: `surv_traceback`

## Requirements
- R1: After reset, out_valid is low. No bit is output until three complete groups (63 stages) have been stored.
- R2: Beat k (k = 0..7) of a stage carries in_dec[0] as the decision of state 2k and in_dec[1] as the decision of state 2k+1. A cycle with in_valid low is ignored and changes no stored data. Every eight accepted beats form one stage.
- R3: Stage t is stored in bank t mod 3, row floor(t/3) mod 28. The write and read row pointers are each one-hot at all times. During traceback, the read pointer moves one row downward on every cycle.
- R4: A traceback begins at the newest stage from state 0. For each stage t it forms the older state as {s[2:0], d_t[s]}, where d_t[s] is bit s of that stage's decision word. It covers 42 stages, and the states it visits produce no output.
- R5: The decode run continues from the state where the traceback ended and covers the 21 next-older stages. The decoded bit of stage t is the MSB of the state held just before stepping through stage t. The stack never holds more than 21 bits.
- R6: A run starts when the last beat of each 21-stage group is stored, from the third group onward, and only when the engine is idle.
- R7: Each run outputs 21 bits in increasing stage order. out_valid is high for exactly 21 consecutive cycles, and the first of them is the cycle that follows the 21st rising edge after the edge that stored the group's last beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Beat qualifier for in_dec |
| in_dec | input | 2 | Two survivor decisions (states 2k, 2k+1) |
| out_valid | output | 1 | Decoded bit strobe |
| out_bit | output | 1 | Decoded bit, oldest stage first |

## Verification
The stages are driven in four kinds of groups: all-zero decisions, all-one decisions, words that alternate between 0xAAAA and 0x5555, and random words. Idle cycles are inserted at random between beats. All-zero groups pin down run timing and framing while the path stays on state 0. All-one groups drive the state to 15, which exposes a wrong shift direction or a wrong MSB pick. Alternating words give even and odd states different decisions, so swapped decision lanes or a misplaced beat show up. Random words, run over many pointer wraps, separate wrong bank or row mapping, wrong traceback depth and wrong output order, while the idle gaps show that unqualified beats are ignored.

// File: rtl/svt_pkg.sv
`timescale 1ns/1ps
package svt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_TRACE  = 2'd1,
    PH_DECODE = 2'd2,
    PH_DRAIN  = 2'd3
  } phase_t;
endpackage

// File: rtl/dec_writer.sv
`timescale 1ns/1ps
module dec_writer #(
  parameter int unsigned SBITS        = 4,
  parameter int unsigned BEAT_W       = 2,
  parameter int unsigned BANKS        = 3,
  parameter int unsigned ROWS         = 28,
  parameter int unsigned GROUP_ROWS   = 7,
  parameter int unsigned PRIME_GROUPS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [BEAT_W-1:0]       in_dec,
  output logic [(1<<SBITS)-1:0]   wr_word,
  output logic [BANKS-1:0]        wr_bank_we,
  output logic [ROWS-1:0]         wr_row_oh,
  output logic                    run_start
);
  localparam int unsigned NST   = 1 << SBITS;
  localparam int unsigned BEATS = NST / BEAT_W;
  localparam int unsigned BCW   = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int unsigned GCW   = $clog2(PRIME_GROUPS + 1);

  function automatic logic [ROWS-1:0] group_end_mask();
    logic [ROWS-1:0] m;
    for (int i = 0; i < ROWS; i++) begin
      m[i] = ((i % GROUP_ROWS) == (GROUP_ROWS - 1));
    end
    return m;
  endfunction

  localparam logic [ROWS-1:0] GEND = group_end_mask();

  logic [BCW-1:0]   beat_q,  beat_d;
  logic [NST-1:0]   shreg_q, shreg_d;
  logic [BANKS-1:0] bank_q,  bank_d;
  logic [ROWS-1:0]  row_q,   row_d;
  logic [GCW-1:0]   grp_q,   grp_d;
  logic             word_done, row_done, grp_done;

  assign wr_word    = {in_dec, shreg_q[NST-1:BEAT_W]};
  assign word_done  = in_valid && (beat_q == BCW'(BEATS - 1));
  assign row_done   = word_done && bank_q[BANKS-1];
  assign grp_done   = row_done && (|(row_q & GEND));
  assign run_start  = grp_done && (grp_q == GCW'(PRIME_GROUPS));
  assign wr_bank_we = word_done ? bank_q : '0;
  assign wr_row_oh  = row_q;

  always_comb begin
    beat_d  = beat_q;
    shreg_d = shreg_q;
    bank_d  = bank_q;
    row_d   = row_q;
    grp_d   = grp_q;
    if (in_valid) begin
      shreg_d = {in_dec, shreg_q[NST-1:BEAT_W]};
      beat_d  = word_done ? '0 : beat_q + BCW'(1);
    end
    if (word_done) begin
      bank_d = {bank_q[BANKS-2:0], bank_q[BANKS-1]};
    end
    if (row_done) begin
      row_d = {row_q[ROWS-2:0], row_q[ROWS-1]};
    end
    if (grp_done && (grp_q != GCW'(PRIME_GROUPS))) begin
      grp_d = grp_q + GCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q  <= '0;
      shreg_q <= '0;
      bank_q  <= BANKS'(1);
      row_q   <= ROWS'(1);
      grp_q   <= '0;
    end else begin
      beat_q  <= beat_d;
      shreg_q <= shreg_d;
      bank_q  <= bank_d;
      row_q   <= row_d;
      grp_q   <= grp_d;
    end
  end
endmodule

// File: rtl/surv_bank.sv
`timescale 1ns/1ps
module surv_bank #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned ROWS  = 28
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ROWS-1:0]  wr_row_oh,
  input  logic [WIDTH-1:0] wr_word,
  input  logic [ROWS-1:0]  rd_row_oh,
  output logic [WIDTH-1:0] rd_word
);
  logic [WIDTH-1:0] mem_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (we && wr_row_oh[r]) begin
        mem_q[r] <= wr_word;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (rd_row_oh[r]) begin
        rd_word = rd_word | mem_q[r];
      end
    end
  end
endmodule

// File: rtl/trace_ctrl.sv
`timescale 1ns/1ps
module trace_ctrl
  import svt_pkg::*;
#(
  parameter int unsigned SBITS       = 4,
  parameter int unsigned BANKS       = 3,
  parameter int unsigned ROWS        = 28,
  parameter int unsigned TRACE_ROWS  = 14,
  parameter int unsigned DEC_ROWS    = 7,
  parameter int unsigned START_STATE = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run_start,
  input  logic [ROWS-1:0]               start_row_oh,
  input  logic [BANKS*(1<<SBITS)-1:0]   rd_words,
  output logic [ROWS-1:0]               rd_row_oh,
  output logic                          push,
  output logic [BANKS-1:0]              push_bits,
  output logic                          drain,
  output phase_t                        phase
);
  localparam int unsigned NST       = 1 << SBITS;
  localparam int unsigned DRAIN_LEN = DEC_ROWS * BANKS;
  localparam int unsigned MAXC      = (TRACE_ROWS > DRAIN_LEN) ? TRACE_ROWS : DRAIN_LEN;
  localparam int unsigned CW        = $clog2(MAXC + 1);

  phase_t           ph_q,  ph_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [SBITS-1:0] st_q,  st_d;
  logic [ROWS-1:0]  rd_q,  rd_d;
  logic [BANKS:0][SBITS-1:0] chain;

  assign chain[BANKS] = st_q;
  for (genvar b = 0; b < BANKS; b++) begin : g_step
    logic [NST-1:0] w;
    assign w            = rd_words[b*NST +: NST];
    assign chain[b]     = {chain[b+1][SBITS-2:0], w[chain[b+1]]};
    assign push_bits[b] = chain[b+1][SBITS-1];
  end

  assign rd_row_oh = rd_q;
  assign push      = (ph_q == PH_DECODE);
  assign drain     = (ph_q == PH_DRAIN);
  assign phase     = ph_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    st_d  = st_q;
    rd_d  = rd_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (run_start) begin
          ph_d  = PH_TRACE;
          cnt_d = '0;
          st_d  = SBITS'(START_STATE);
          rd_d  = start_row_oh;
        end
      end
      PH_TRACE, PH_DECODE: begin
        st_d  = chain[0];
        rd_d  = {rd_q[0], rd_q[ROWS-1:1]};
        cnt_d = cnt_q + CW'(1);
        if (ph_q == PH_TRACE && cnt_q == CW'(TRACE_ROWS - 1)) begin
          ph_d  = PH_DECODE;
          cnt_d = '0;
        end else if (ph_q == PH_DECODE && cnt_q == CW'(DEC_ROWS - 1)) begin
          ph_d  = PH_DRAIN;
          cnt_d = '0;
        end
      end
      PH_DRAIN: begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == CW'(DRAIN_LEN - 1)) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      st_q  <= '0;
      rd_q  <= ROWS'(1);
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      st_q  <= st_d;
      rd_q  <= rd_d;
    end
  end
endmodule

// File: rtl/bit_lifo.sv
`timescale 1ns/1ps
module bit_lifo #(
  parameter int unsigned DEPTH = 21,
  parameter int unsigned PUSHW = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [PUSHW-1:0]           push_bits,
  input  logic                       pop,
  output logic                       top,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] stk_q, stk_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  assign top   = stk_q[0];
  assign count = cnt_q;

  always_comb begin
    stk_d = stk_q;
    cnt_d = cnt_q;
    if (push) begin
      stk_d = {stk_q[DEPTH-1-PUSHW:0], push_bits};
      cnt_d = cnt_q + CW'(PUSHW);
    end else if (pop && cnt_q != '0) begin
      stk_d = {1'b0, stk_q[DEPTH-1:1]};
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk_q <= '0;
      cnt_q <= '0;
    end else begin
      stk_q <= stk_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/surv_traceback.sv
`timescale 1ns/1ps
module surv_traceback
  import svt_pkg::*;
#(
  parameter int unsigned SBITS       = 4,
  parameter int unsigned BEAT_W      = 2,
  parameter int unsigned BANKS       = 3,
  parameter int unsigned ROWS        = 28,
  parameter int unsigned TRACE_ROWS  = 14,
  parameter int unsigned DEC_ROWS    = 7,
  parameter int unsigned START_STATE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BEAT_W-1:0] in_dec,
  output logic              out_valid,
  output logic              out_bit
);
  localparam int unsigned NST          = 1 << SBITS;
  localparam int unsigned DRAIN_LEN    = DEC_ROWS * BANKS;
  localparam int unsigned PRIME_GROUPS = TRACE_ROWS / DEC_ROWS;
  localparam int unsigned LCW          = $clog2(DRAIN_LEN + 1);

  logic [1:0]            rst_sync_q;
  logic                  core_rst_n;
  logic [NST-1:0]        wr_word;
  logic [BANKS-1:0]      wr_bank_we;
  logic [ROWS-1:0]       wr_row_oh;
  logic [ROWS-1:0]       rd_row_oh;
  logic                  run_start;
  logic [BANKS*NST-1:0]  rd_flat;
  logic                  push;
  logic [BANKS-1:0]      push_bits;
  logic                  drain;
  phase_t                phase;
  logic [LCW-1:0]        lifo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  dec_writer #(
    .SBITS(SBITS), .BEAT_W(BEAT_W), .BANKS(BANKS), .ROWS(ROWS),
    .GROUP_ROWS(DEC_ROWS), .PRIME_GROUPS(PRIME_GROUPS)
  ) u_writer (
    .clk(clk), .rst_n(core_rst_n), .in_valid(in_valid), .in_dec(in_dec),
    .wr_word(wr_word), .wr_bank_we(wr_bank_we), .wr_row_oh(wr_row_oh),
    .run_start(run_start)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    surv_bank #(.WIDTH(NST), .ROWS(ROWS)) u_bank (
      .clk(clk), .we(wr_bank_we[b]), .wr_row_oh(wr_row_oh),
      .wr_word(wr_word), .rd_row_oh(rd_row_oh),
      .rd_word(rd_flat[b*NST +: NST])
    );
  end

  trace_ctrl #(
    .SBITS(SBITS), .BANKS(BANKS), .ROWS(ROWS), .TRACE_ROWS(TRACE_ROWS),
    .DEC_ROWS(DEC_ROWS), .START_STATE(START_STATE)
  ) u_trace (
    .clk(clk), .rst_n(core_rst_n), .run_start(run_start),
    .start_row_oh(wr_row_oh), .rd_words(rd_flat), .rd_row_oh(rd_row_oh),
    .push(push), .push_bits(push_bits), .drain(drain), .phase(phase)
  );

  bit_lifo #(.DEPTH(DRAIN_LEN), .PUSHW(BANKS)) u_lifo (
    .clk(clk), .rst_n(core_rst_n), .push(push), .push_bits(push_bits),
    .pop(drain), .top(out_bit), .count(lifo_cnt)
  );

  assign out_valid = drain;
endmodule

// File: rtl/surv_traceback_chk.sv
`timescale 1ns/1ps
module surv_traceback_chk
  import svt_pkg::*;
#(
  parameter int unsigned ROWS         = 28,
  parameter int unsigned LCW          = 5,
  parameter int unsigned DEPTH        = 21,
  parameter int unsigned BEATS        = 8,
  parameter int unsigned PRIME_STAGES = 63
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            out_valid,
  input logic            run_start,
  input logic [ROWS-1:0] wr_row_oh,
  input logic [ROWS-1:0] rd_row_oh,
  input logic [LCW-1:0]  lifo_cnt,
  input phase_t          phase
);
  int unsigned beats_q;
  int unsigned burst_q;
  logic        ov_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats_q <= 0;
      burst_q <= 0;
      ov_q    <= 1'b0;
    end else begin
      if (in_valid && beats_q < PRIME_STAGES * BEATS) beats_q <= beats_q + 1;
      ov_q <= out_valid;
      if (out_valid) burst_q <= ov_q ? burst_q + 1 : 1;
    end
  end

  AST_WR_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_row_oh) == 1); // R3
  AST_RD_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_row_oh) == 1); // R3
  AST_RD_MOVES_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TRACE && $past(phase) == PH_TRACE) |->
      $past(rd_row_oh) == {rd_row_oh[ROWS-2:0], rd_row_oh[ROWS-1]}); // R3
  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> beats_q >= PRIME_STAGES * BEATS); // R1
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |-> phase == PH_IDLE); // R6
  AST_LIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lifo_cnt <= LCW'(DEPTH)); // R5
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> burst_q == DEPTH); // R7
endmodule

bind surv_traceback surv_traceback_chk #(
  .ROWS(ROWS), .LCW(LCW), .DEPTH(DRAIN_LEN), .BEATS(NST / BEAT_W),
  .PRIME_STAGES((PRIME_GROUPS + 1) * DRAIN_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .run_start(run_start), .wr_row_oh(wr_row_oh), .rd_row_oh(rd_row_oh),
  .lifo_cnt(lifo_cnt), .phase(phase)
);

// File: tb/surv_traceback_test.sv
`timescale 1ns/1ps
module surv_traceback_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_dec = 2'b00;
  logic       out_valid;
  logic       out_bit;

  int unsigned vectors = 0;
  int unsigned errors  = 0;
  bit          finished = 1'b0;

  surv_traceback uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dec(in_dec),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  always #2 clk = ~clk;

  // behavioural reference: stage list, traceback by integer arithmetic
  logic [15:0] stq[$];
  logic [15:0] acc;
  int          beat;
  longint      cyc;
  longint      run_base;
  bit          run_on;
  bit          exp_bits[21];

  function automatic int step_back(int s, logic [15:0] w);
    return ((s << 1) & 15) | int'(w[s]);
  endfunction

  task automatic plan_run();
    int last;
    int s;
    last = stq.size() - 1;
    s = 0;
    for (int t = last; t > last - 42; t--) s = step_back(s, stq[t]);      // R4
    for (int t = last - 42; t > last - 63; t--) begin                      // R5
      exp_bits[t - (last - 62)] = ((s >> 3) & 1) != 0;
      s = step_back(s, stq[t]);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stq.delete();
      acc = '0; beat = 0; cyc = 0; run_on = 1'b0; run_base = 0;
    end else begin
      cyc = cyc + 1;
      if (in_valid) begin                                                  // R2
        acc[2*beat]   = in_dec[0];
        acc[2*beat+1] = in_dec[1];
        beat = beat + 1;
        if (beat == 8) begin
          stq.push_back(acc);
          beat = 0;
          if (stq.size() % 21 == 0 && stq.size() >= 63) begin              // R6
            plan_run();
            run_on = 1'b1;
            run_base = cyc;
          end
        end
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      bit exp_v;
      int idx;
      exp_v = 1'b0;
      idx = 0;
      if (!rst_n) begin
        vectors++;
        if (out_valid !== 1'b0) begin
          errors++;
          $display("FAIL R1 reset: out_valid got %0b expected 0", out_valid);
        end
      end else begin
        if (run_on && cyc >= run_base + 21 && cyc <= run_base + 41) begin  // R7
          exp_v = 1'b1;
          idx = int'(cyc - run_base - 21);
        end
        vectors++;
        if (out_valid !== exp_v) begin
          errors++;
          if (stq.size() < 63)
            $display("FAIL R1 early output cycle %0d: out_valid got %0b expected %0b", cyc, out_valid, exp_v);
          else
            $display("FAIL R7 timing cycle %0d: out_valid got %0b expected %0b", cyc, out_valid, exp_v);
        end
        if (exp_v) begin
          vectors++;
          if (out_bit !== exp_bits[idx]) begin
            errors++;
            $display("FAIL R5 bit %0d cycle %0d: out_bit got %0b expected %0b", idx, cyc, out_bit, exp_bits[idx]);
          end
        end
      end
    end
  end

  function automatic logic [15:0] make_word(int t);
    case ((t / 21) % 4)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return (t % 2 == 1) ? 16'hAAAA : 16'h5555;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic send_stage(logic [15:0] w);
    for (int k = 0; k < 8; k++) begin
      if ($urandom % 4 == 0) begin                                         // R2 idle beat ignored
        in_valid = 1'b0;
        in_dec = 2'($urandom);
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_dec = w[2*k +: 2];
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    for (int t = 0; t < 16 * 21; t++) begin                                // R3 wraps the 28 rows
      send_stage(make_word(t));
    end
    repeat (80) @(negedge clk);
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run got hung expected completion");
    report();
  end
endmodule